// File: doc/BRIEF.md
# Canonical-Sign Walk Stage with Fruitless-Cycle Escape

This stage sits inside a pseudo-random walk over the points of an elliptic curve defined over a binary field. Each new affine point (x, y) arrives with a valid strobe. The stage picks one sign for the point: it compares y with the negated coordinate x XOR y and keeps the smaller one. It also remembers the x-coordinates of the last few points in the current walk.

When an incoming x equals one seen k strobes earlier, the walk has closed a fruitless loop of length k. The stage then raises a flag and advances an escape offset by k. The offset is added to a base index taken from fixed low bits of x, and the sum selects the next entry of a 1024-entry branching table. Because the next step uses a different table entry, the walk leaves the loop deterministically. No restart and no point doubling are needed.

A start signal marks the first point of a fresh walk and forgets all earlier walk state. A clear returns the whole stage to its reset state. Every result is registered and appears one clock after the strobe.

Top module: `walk_canon_escape`

## Requirements
- R1: One clock after a cycle with ptValid=1 and clear=0, outValid is 1 and canonY holds the smaller of ptY and ptX^ptY, both read as unsigned integers.
- R2: With a valid strobe, branchIdx one clock later equals (ptX[9:0] + escape offset) mod 1024, using the offset as updated by that same point.
- R3: If the x of a valid point equals the x of the point k valid strobes earlier in the current history (1 ≤ k ≤ 10), cycleHit is 1 one clock later. Otherwise cycleHit is 0.
- R4: A point whose x matches only a point 11 or more valid strobes back is not reported as a cycle, and the offset does not change.
- R5: On a detection of length k, the escape offset grows by k, modulo 1024, before it is added for that point's branchIdx.
- R6: After a detection, the history holds only the detecting point. A later point that matches only older points is not a cycle.
- R7: loadStart sets the offset to 0 and empties the history. A point strobed together with loadStart is the first point of a new walk and never reports a cycle.
- R8: clear is synchronous and acts like reset. One clock later outValid, cycleHit, branchIdx and canonY are 0, the history is empty and the offset is 0. A point strobed together with clear is dropped.
- R9: After reset, outValid, cycleHit, branchIdx and canonY are all 0.
- R10: In a cycle without ptValid, outValid and cycleHit are 0 one clock later. canonY and branchIdx keep their values, and the history is unchanged.
- R11: If a walk that escaped a 2-cycle with offset 2 falls into another 2-cycle, the offset becomes 4, so the branch is ptX[9:0]+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous return to the reset state |
| loadStart | input | 1 | First point of a fresh walk; empties history and offset |
| ptValid | input | 1 | A new point is on ptX/ptY |
| ptX | input | 113 | Affine x-coordinate |
| ptY | input | 113 | Affine y-coordinate |
| outValid | output | 1 | Registered results belong to a point |
| canonY | output | 113 | y-coordinate of the chosen sign |
| cycleHit | output | 1 | The point closed a loop of length 1..10 |
| branchIdx | output | 10 | Branching-table index for the next step |

## Verification
The in-module assertions check, on every cycle, the one-clock output timing and that canonY is never the larger of the two sign choices. They also check that the offset stays put when nothing is detected, that it returns to zero after a start, that a flush leaves exactly one history entry, and that an idle cycle holds canonY. Only the bench scenarios can show the cases that depend on the walk's order. These cover the exact loop length that is reported, the limit at a depth of ten and eleven, a repeated 2-cycle being escaped by an offset of four, the wrap of the offset past 1024, and old points being forgotten after a flush or a new start.

// File: rtl/walk_pkg.sv
package walk_pkg;
  // Strobes from control to datapath, one set per clock.
  typedef struct packed {
    logic take;   // a point is accepted this cycle
    logic load;   // point starts a fresh walk
    logic flush;  // a loop was detected on this point
    logic wipe;   // synchronous clear of all state
  } walkStrobe_t;
endpackage

// File: rtl/signCanon.sv
module signCanon #(
  parameter int W = 113
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] yCanon
);
  logic [W-1:0] yNeg;
  logic         pickNeg;

  always_comb begin
    yNeg    = x ^ y;
    pickNeg = (yNeg < y);
    yCanon  = pickNeg ? yNeg : y;
  end
endmodule

// File: rtl/walkDatapath.sv
module walkDatapath
  import walk_pkg::*;
#(
  parameter int W       = 113,
  parameter int DEPTH   = 10,
  parameter int IDX_W   = 10,
  parameter int IDX_LSB = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       strobe,
  input  logic [W-1:0]      ptX,
  input  logic [W-1:0]      ptY,
  output logic [DEPTH-1:0]  matchVec,
  output logic [IDX_W-1:0]  baseIdx,
  output logic [W-1:0]      canonY,
  output logic              outValid
);
  logic [W-1:0]     histX [DEPTH];
  logic [DEPTH-1:0] histV;
  logic [W-1:0]     yCanon;
  logic             restart;

  signCanon #(.W(W)) u_canon (
    .x      (ptX),
    .y      (ptY),
    .yCanon (yCanon)
  );

  assign baseIdx = ptX[IDX_LSB +: IDX_W];
  assign restart = strobe.flush | strobe.load;

  // One comparator per history slot; slot g holds the point g+1 strobes back.
  for (genvar g = 0; g < DEPTH; g++) begin : gCmp
    assign matchVec[g] = histV[g] & (histX[g] == ptX);
  end

  always_ff @(posedge clk) begin
    if (strobe.take) begin
      histX[0] <= ptX;
      if (!restart) begin
        for (int i = 1; i < DEPTH; i++) histX[i] <= histX[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      histV    <= '0;
      outValid <= 1'b0;
      canonY   <= '0;
    end else if (strobe.wipe) begin
      histV    <= '0;
      outValid <= 1'b0;
      canonY   <= '0;
    end else begin
      outValid <= strobe.take;
      if (strobe.take) begin
        canonY <= yCanon;
        if (restart) histV <= DEPTH'(1);
        else         histV <= {histV[DEPTH-2:0], 1'b1};
      end else if (strobe.load) begin
        histV <= '0;
      end
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> outValid == ($past(strobe.take) && !$past(strobe.wipe))); // R1
  AST_CANON_NOT_LARGER: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.take && !strobe.wipe) |=> canonY <= ($past(ptX) ^ canonY)); // R1
  AST_FLUSH_ONE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.take && restart && !strobe.wipe) |=> histV == DEPTH'(1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.take && !strobe.wipe) |=> $stable(canonY)); // R10
endmodule

// File: rtl/walkControl.sv
module walkControl
  import walk_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             loadStart,
  input  logic             ptValid,
  input  logic [DEPTH-1:0] matchVec,
  input  logic [IDX_W-1:0] baseIdx,
  output walkStrobe_t      strobe,
  output logic             cycleHit,
  output logic [IDX_W-1:0] branchIdx
);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] offQ;
  logic [IDX_W-1:0] offBase;
  logic [IDX_W-1:0] offNext;
  logic [LEN_W-1:0] hitLen;
  logic [IDX_W-1:0] hitLenExt;
  logic             hitAny;

  // Shortest matching depth wins.
  always_comb begin
    hitLen = '0;
    for (int k = DEPTH; k >= 1; k--) begin
      if (matchVec[k-1]) hitLen = LEN_W'(k);
    end
  end

  always_comb begin
    hitAny    = ptValid & ~loadStart & (|matchVec);
    hitLenExt = IDX_W'(hitLen);
    offBase   = loadStart ? '0 : offQ;
    offNext   = offBase + (hitAny ? hitLenExt : '0);
    strobe.take  = ptValid;
    strobe.load  = loadStart;
    strobe.flush = hitAny;
    strobe.wipe  = clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offQ      <= '0;
      cycleHit  <= 1'b0;
      branchIdx <= '0;
    end else if (clear) begin
      offQ      <= '0;
      cycleHit  <= 1'b0;
      branchIdx <= '0;
    end else if (ptValid) begin
      offQ      <= offNext;
      cycleHit  <= hitAny;
      branchIdx <= baseIdx + offNext;
    end else begin
      cycleHit <= 1'b0;
      if (loadStart) offQ <= '0;
    end
  end

  AST_HIT_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hitAny |-> (hitLen >= LEN_W'(1) && hitLen <= LEN_W'(DEPTH))); // R3
  AST_HIT_NEEDS_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    cycleHit |-> $past(ptValid)); // R3
  AST_START_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (loadStart && !clear) |=> offQ == '0); // R7
  AST_OFF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ptValid && !loadStart && !hitAny && !clear) |=> offQ == $past(offQ)); // R5
  AST_ESCAPE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hitAny && !clear) |=> branchIdx == $past(baseIdx) + $past(offQ) + $past(hitLenExt)); // R5
endmodule

// File: rtl/walk_canon_escape.sv
module walk_canon_escape
  import walk_pkg::*;
#(
  parameter int FIELD_W    = 113,
  parameter int HIST_DEPTH = 10,
  parameter int TABLE_SIZE = 1024,
  parameter int IDX_LSB    = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          loadStart,
  input  logic                          ptValid,
  input  logic [FIELD_W-1:0]            ptX,
  input  logic [FIELD_W-1:0]            ptY,
  output logic                          outValid,
  output logic [FIELD_W-1:0]            canonY,
  output logic                          cycleHit,
  output logic [$clog2(TABLE_SIZE)-1:0] branchIdx
);
  localparam int IDX_W = $clog2(TABLE_SIZE);

  walkStrobe_t           strobe;
  logic [HIST_DEPTH-1:0] matchVec;
  logic [IDX_W-1:0]      baseIdx;

  walkControl #(.DEPTH(HIST_DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .loadStart (loadStart),
    .ptValid   (ptValid),
    .matchVec  (matchVec),
    .baseIdx   (baseIdx),
    .strobe    (strobe),
    .cycleHit  (cycleHit),
    .branchIdx (branchIdx)
  );

  walkDatapath #(.W(FIELD_W), .DEPTH(HIST_DEPTH), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .ptX      (ptX),
    .ptY      (ptY),
    .matchVec (matchVec),
    .baseIdx  (baseIdx),
    .canonY   (canonY),
    .outValid (outValid)
  );
endmodule

// File: tb/walk_canon_escape_tb.sv
`timescale 1ns/1ps
module walk_canon_escape_tb;
  localparam int W = 113;
  localparam int D = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0, loadStart = 1'b0, ptValid = 1'b0;
  logic [W-1:0] ptX = '0, ptY = '0;
  logic         outValid, cycleHit;
  logic [W-1:0] canonY;
  logic [9:0]   branchIdx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state
  logic [W-1:0] mHist [D];
  bit   [D-1:0] mHv = '0;
  logic [9:0]   mOff = '0;
  logic [W-1:0] eY = '0;
  logic [9:0]   eBr = '0;
  bit           eHit = 1'b0, eV = 1'b0;

  always #4 clk = ~clk;

  walk_canon_escape u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .loadStart(loadStart),
    .ptValid(ptValid), .ptX(ptX), .ptY(ptY), .outValid(outValid),
    .canonY(canonY), .cycleHit(cycleHit), .branchIdx(branchIdx)
  );

  function automatic logic [W-1:0] rnd113();
    logic [127:0] t = {$urandom(), $urandom(), $urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] smallerY(logic [W-1:0] x, logic [W-1:0] y);
    return ((x ^ y) < y) ? (x ^ y) : y;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input bit v, input bit ld, input bit clr, input logic [W-1:0] x, input logic [W-1:0] y);
    int hk;
    if (clr) begin
      mHv = '0; mOff = '0; eV = 0; eHit = 0; eBr = '0; eY = '0;
      return;
    end
    if (ld) begin mHv = '0; mOff = '0; end
    eV = v; eHit = 0;
    if (!v) return;
    hk = 0;
    for (int k = D; k >= 1; k--) if (mHv[k-1] && mHist[k-1] == x) hk = k;
    if (hk != 0) begin
      eHit = 1;
      mOff = mOff + 10'(hk);
      mHv = '0; mHv[0] = 1; mHist[0] = x;
    end else begin
      for (int i = D-1; i > 0; i--) mHist[i] = mHist[i-1];
      mHist[0] = x;
      mHv = {mHv[D-2:0], 1'b1};
    end
    eBr = x[9:0] + mOff;
    eY = smallerY(x, y);
  endtask

  task automatic step(input bit v, input bit ld, input bit clr, input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    ptValid = v; loadStart = ld; clear = clr; ptX = x; ptY = y;
    @(posedge clk);
    modelStep(v, ld, clr, x, y);
    @(negedge clk);
    chk(outValid == eV, {tag, " R1 outValid"}, 128'(outValid), 128'(eV));
    chk(cycleHit == eHit, {tag, " R3 cycleHit"}, 128'(cycleHit), 128'(eHit));
    chk(branchIdx == eBr, {tag, " R2 R5 branchIdx"}, 128'(branchIdx), 128'(eBr));
    chk(canonY == eY, {tag, " R1 canonY"}, 128'(canonY), 128'(eY));
  endtask

  task automatic pt(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    step(1'b1, 1'b0, 1'b0, x, y, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pa, pb, pc, pd, pe, pz;
    logic [W-1:0] pool [12];
    void'($urandom(32'h5EED));
    for (int i = 0; i < 12; i++) pool[i] = rnd113();
    pa = rnd113(); pb = rnd113(); pc = rnd113(); pd = rnd113(); pe = rnd113();
    pz = rnd113();

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(outValid == 0, "R9 outValid", 128'(outValid), 128'(0));
    chk(cycleHit == 0, "R9 cycleHit", 128'(cycleHit), 128'(0));
    chk(branchIdx == 0, "R9 branchIdx", 128'(branchIdx), 128'(0));
    chk(canonY == 0, "R9 canonY", 128'(canonY), 128'(0));

    // R3 R5: simple 2-cycle, then R11 a second 2-cycle, then R6 forgetting
    step(1, 1, 0, pa, pz, "R7 start");
    pt(pb, pe, "walk");
    pt(pa, pd, "R3 2-cycle");
    pt(pc, pb, "after escape");
    pt(pa, pc, "R11 second 2-cycle");
    chk(branchIdx == pa[9:0] + 10'd4, "R11 branch j+4", 128'(branchIdx), 128'(pa[9:0] + 10'd4));
    pt(pd, pa, "R6 fill");
    pt(pb, pa, "R6 old point forgotten");
    chk(cycleHit == 0, "R6 no hit", 128'(cycleHit), 128'(0));

    // R3 depth-10 limit, R4 depth 11
    step(1, 1, 0, pool[0], pz, "R7 start");
    for (int i = 1; i < 10; i++) pt(pool[i], pb, "R3 fill");
    pt(pool[0], pc, "R3 10-cycle");
    chk(cycleHit == 1, "R3 depth10", 128'(cycleHit), 128'(1));
    step(1, 1, 0, pool[0], pz, "R7 start");
    for (int i = 1; i < 11; i++) pt(pool[i], pb, "R4 fill");
    pt(pool[0], pc, "R4 11-cycle");
    chk(cycleHit == 0, "R4 depth11", 128'(cycleHit), 128'(0));

    // R10 idle cycles hold outputs and history
    pt(pd, pe, "R10 before idle");
    step(0, 0, 0, pa, pb, "R10 idle");
    step(0, 0, 0, pc, pb, "R10 idle");
    pt(pd, pa, "R10 history kept");

    // R7 start with a point that matches old history
    step(1, 1, 0, pd, pa, "R7 start no hit");
    chk(cycleHit == 0, "R7 no hit", 128'(cycleHit), 128'(0));
    step(0, 1, 0, pa, pa, "R7 start idle");
    pt(pd, pb, "R7 history emptied");

    // R8 clear with a point
    pt(pe, pc, "R8 before clear");
    step(1, 0, 1, pe, pc, "R8 clear");
    chk(branchIdx == 0 && canonY == 0, "R8 zeroed", 128'(branchIdx), 128'(0));
    pt(pe, pa, "R8 point dropped");

    // R5 R2 offset wrap via repeated 2-cycles
    step(1, 1, 0, pa, pb, "R7 start");
    for (int i = 0; i < 1100; i++) pt((i % 2 == 0) ? pb : pa, pc, "R5 wrap");

    // random walk
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [W-1:0] x = ($urandom_range(0, 9) < 7) ? pool[$urandom_range(0, 5)] : rnd113();
      logic [W-1:0] y = rnd113();
      if (r < 2)       step(1, 0, 1, x, y, "R8 rnd");
      else if (r < 5)  step(1, 1, 0, x, y, "R7 rnd");
      else if (r < 12) step(0, 0, 0, x, y, "R10 rnd");
      else             step(1, 0, 0, x, y, "R3 rnd");
    end

    ptValid = 0; loadStart = 0; clear = 0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule